// File: doc/BRIEF.md
# Receive-Level Flow Control Generator

This block watches how full a receive FIFO is and throttles the far end when it fills up. A single hysteresis state tracks whether the link is throttled. The state is set when the fill level reaches an upper threshold. It is cleared when the fill level falls below a lower threshold. That one state drives two kinds of flow control.

The first is in-band: the block asks the serial transmitter to slip a stop character or a resume character into the outgoing stream. It uses a request/accept handshake and a character pair chosen by a mode field. The second is out-of-band: the block drives an active-low request-to-send line, which is forced high while throttled.

Both kinds are active only while the enhanced-function bit is set. In-band insertion is also suppressed while the port carries 9-bit characters.

Top module: `fcg_flow_ctl`

## Requirements
- R1: After reset the block is not throttled, `ins_req` is 0, `ins_char` is 0 and `rts_n` is 0.
- R2: When the link is not throttled and `rx_level >= thr_hi` is sampled at a clock edge, the link becomes throttled at that edge. If insertion is enabled, exactly one stop-character request is raised at the same edge.
- R3: When the link is throttled and `rx_level` is sampled below the effective lower threshold, the link is released at that edge. If insertion is enabled, exactly one resume-character request is raised at the same edge.
- R4: `tx_mode` selects the character pair. The value 2'b01 uses `xon2`/`xoff2`. The value 2'b10 uses `xon1`/`xoff1`. The values 2'b00 and the reserved 2'b11 raise no request.
- R5: Insertion is enabled only when `enh_en` is 1, `nine_bit` is 0 and `tx_mode` is 01 or 10. While insertion is disabled, `ins_req` is 0 from the next edge on, and any pending request is dropped.
- R6: A pending request keeps `ins_req` high and `ins_char` unchanged until an edge that samples `ins_ack` high. `ins_req` is low after that edge, unless a new event arrives at that same edge.
- R7: If a release occurs while a stop-character request is still unaccepted, the request is replaced by the resume character rather than queued.
- R8: `rts_n` is 1 exactly when `enh_en` and `rts_auto` are both 1 and the link is throttled; otherwise it is 0.
- R9: While throttled, `rx_level` values between the lower and upper thresholds leave the state, `rts_n` and the request unchanged.
- R10: If `thr_lo >= thr_hi`, the effective lower threshold is `thr_hi`, so the release happens when `rx_level < thr_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| thr_hi | input | LVL_W | Upper (throttle) threshold |
| thr_lo | input | LVL_W | Lower (release) threshold |
| enh_en | input | 1 | Enhanced-function enable; gates everything else |
| tx_mode | input | 2 | In-band character pair select |
| rts_auto | input | 1 | Automatic request-to-send enable |
| nine_bit | input | 1 | 9-bit character mode; suppresses insertion |
| xon1 | input | 8 | Resume character, pair 1 |
| xon2 | input | 8 | Resume character, pair 2 |
| xoff1 | input | 8 | Stop character, pair 1 |
| xoff2 | input | 8 | Stop character, pair 2 |
| ins_ack | input | 1 | Transmitter accepts the pending insertion |
| ins_req | output | 1 | Insertion request pending |
| ins_char | output | 8 | Character to insert |
| rts_n | output | 1 | Active-low request-to-send line |

## Verification
The hardest situation to reach is a stop request that is still unaccepted when the fill level has already drained below the lower threshold. The bench reaches it by switching off its automatic acknowledger, pushing the level over the upper threshold and then straight under the lower one. It then confirms that the request now carries the resume character and that only one acceptance follows. In the same way, a pending request is left hanging while the enhanced bit is dropped, to show that the request is discarded.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int FCG_CHAR_W = 8;

    typedef enum logic [1:0] {
        TXM_OFF   = 2'b00,
        TXM_PAIR2 = 2'b01,
        TXM_PAIR1 = 2'b10,
        TXM_RSVD  = 2'b11
    } fcg_txmode_e;

    typedef struct packed {
        logic                  pend;
        logic [FCG_CHAR_W-1:0] code;
    } fcg_req_t;
endpackage

// File: rtl/fcg_hyst.sv
module fcg_hyst #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             throttled,
    output logic             enter,
    output logic             leave
);
    logic             thr_d, thr_q;
    logic [LVL_W-1:0] eff_lo;

    always_comb begin
        // A release threshold at or above the upper one collapses onto it.
        eff_lo = (thr_lo < thr_hi) ? thr_lo : thr_hi;
        enter  = !thr_q && (level >= thr_hi);
        leave  = thr_q && (level < eff_lo);
        thr_d  = thr_q;
        if (enter)      thr_d = 1'b1;
        else if (leave) thr_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= 1'b0;
        else        thr_q <= thr_d;
    end

    assign throttled = thr_q;

    AST_RISE_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_q) |-> $past(level >= thr_hi)); // R2
    AST_FALL_BELOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thr_q) |-> $past(level < thr_hi)); // R10
endmodule

// File: rtl/fcg_insert.sv
module fcg_insert
    import fcg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ok,
    input  logic [1:0]            mode,
    input  logic                  enter,
    input  logic                  leave,
    input  logic [FCG_CHAR_W-1:0] xon1,
    input  logic [FCG_CHAR_W-1:0] xon2,
    input  logic [FCG_CHAR_W-1:0] xoff1,
    input  logic [FCG_CHAR_W-1:0] xoff2,
    input  logic                  ack,
    output logic                  req,
    output logic [FCG_CHAR_W-1:0] code
);
    fcg_req_t r_d, r_q;
    logic [FCG_CHAR_W-1:0] stop_c, go_c;

    always_comb begin
        stop_c = (mode == TXM_PAIR2) ? xoff2 : xoff1;
        go_c   = (mode == TXM_PAIR2) ? xon2  : xon1;
        r_d    = r_q;
        if (!ok) begin
            r_d.pend = 1'b0;
        end else if (enter) begin
            r_d.pend = 1'b1;
            r_d.code = stop_c;
        end else if (leave) begin
            // A newer event overwrites whatever is still waiting.
            r_d.pend = 1'b1;
            r_d.code = go_c;
        end else if (ack && r_q.pend) begin
            r_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req  = r_q.pend;
    assign code = r_q.code;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && ok && !enter && !leave) |=> (req && $stable(code))); // R6
    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !req); // R5
endmodule

// File: rtl/fcg_flow_ctl.sv
module fcg_flow_ctl
    import fcg_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             enh_en,
    input  logic [1:0]       tx_mode,
    input  logic             rts_auto,
    input  logic             nine_bit,
    input  logic [7:0]       xon1,
    input  logic [7:0]       xon2,
    input  logic [7:0]       xoff1,
    input  logic [7:0]       xoff2,
    input  logic             ins_ack,
    output logic             ins_req,
    output logic [7:0]       ins_char,
    output logic             rts_n
);
    logic throttled, enter, leave, ins_ok;

    fcg_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk(clk), .rst_n(rst_n), .level(rx_level),
        .thr_hi(thr_hi), .thr_lo(thr_lo),
        .throttled(throttled), .enter(enter), .leave(leave)
    );

    assign ins_ok = enh_en && !nine_bit &&
                    (tx_mode == TXM_PAIR1 || tx_mode == TXM_PAIR2);

    fcg_insert u_insert (
        .clk(clk), .rst_n(rst_n), .ok(ins_ok), .mode(tx_mode),
        .enter(enter), .leave(leave),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .ack(ins_ack), .req(ins_req), .code(ins_char)
    );

    assign rts_n = enh_en && rts_auto && throttled;

    AST_RTS_NEEDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> (enh_en && rts_auto)); // R8
    AST_REQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> $past(ins_ok)); // R4
endmodule

// File: tb/fcg_flow_ctl_bench.sv
module fcg_flow_ctl_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [6:0] rx_level = 0, thr_hi = 96, thr_lo = 32;
    logic       enh_en = 0, rts_auto = 0, nine_bit = 0, ins_ack = 0;
    logic [1:0] tx_mode = 0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h21, xoff1 = 8'h13, xoff2 = 8'h23;
    logic       ins_req, rts_n;
    logic [7:0] ins_char;

    int checks = 0, fails = 0, cycles = 0;
    bit auto_ack = 0;
    int ack_wait = 0;
    // reference model state
    bit m_thr = 0, m_req = 0;
    logic [7:0] m_chr = 0;
    bit model_on = 0;
    int n_stop = 0, n_go = 0;

    always #4 clk = ~clk;

    fcg_flow_ctl u_fcg_flow_ctl (.*);

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference, updated at each edge from pre-edge inputs
    always @(posedge clk) begin
        int lo;
        bit ok, en, lv, acked;
        cycles++;
        if (!rst_n) begin
            m_thr = 0; m_req = 0; m_chr = 0;
        end else begin
            lo = (thr_lo < thr_hi) ? thr_lo : thr_hi;
            en = !m_thr && rx_level >= thr_hi;
            lv = m_thr && rx_level < lo;
            ok = enh_en && !nine_bit && (tx_mode == 1 || tx_mode == 2);
            acked = m_req && ins_ack;
            if (acked && m_chr == ((tx_mode == 1) ? xoff2 : xoff1)) n_stop++;
            else if (acked) n_go++;
            if (en) m_thr = 1; else if (lv) m_thr = 0;
            if (!ok) m_req = 0;
            else if (en) begin m_req = 1; m_chr = (tx_mode == 1) ? xoff2 : xoff1; end
            else if (lv) begin m_req = 1; m_chr = (tx_mode == 1) ? xon2 : xon1; end
            else if (acked) m_req = 0;
        end
        #2;
        if (model_on) begin
            chk(ins_req == m_req, "R2/R3/R5/R6 ins_req", ins_req, m_req);
            if (m_req) chk(ins_char == m_chr, "R4/R7 ins_char", ins_char, m_chr);
            chk(rts_n == ((enh_en && rts_auto) ? m_thr : 0), "R8/R9 rts_n",
                rts_n, (enh_en && rts_auto) ? m_thr : 0);
        end
    end

    // automatic acceptor, driven away from the sampling edge
    always @(negedge clk) begin
        if (auto_ack && ins_req && !ins_ack) begin
            ack_wait++;
            if (ack_wait >= 3) begin ins_ack <= 1; ack_wait = 0; end
        end else ins_ack <= 0;
    end

    always @(posedge clk) if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic ramp(input int from, input int to, input int step);
        for (int v = from; (step > 0) ? v <= to : v >= to; v += step) begin
            @(negedge clk); rx_level = 7'(v);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ins_req == 0, "R1 ins_req", ins_req, 0);
        chk(ins_char == 0, "R1 ins_char", ins_char, 0);
        chk(rts_n == 0, "R1 rts_n", rts_n, 0);
        rst_n = 1; model_on = 1;
        // pair 1, RTS automatic
        enh_en = 1; tx_mode = 2; rts_auto = 1; auto_ack = 1;
        n_stop = 0; n_go = 0;
        ramp(0, 110, 5); ramp(110, 40, -10);   // hover in band: R9
        ramp(40, 0, -8);
        chk(n_stop == 1, "R2 one stop accepted", n_stop, 1);
        chk(n_go == 1, "R3 one resume accepted", n_go, 1);
        // pair 2
        tx_mode = 1; n_stop = 0; n_go = 0;
        ramp(0, 120, 12); ramp(120, 0, -12);
        chk(n_stop == 1 && n_go == 1, "R4 pair2 count", n_stop + n_go, 2);
        // modes 00 and 11: no insertion, RTS still works
        tx_mode = 0; ramp(0, 120, 20); ramp(120, 0, -20);
        tx_mode = 3; ramp(0, 120, 20); ramp(120, 0, -20);
        // enhanced off, then 9-bit
        tx_mode = 2; enh_en = 0; ramp(0, 120, 20); ramp(120, 0, -20);
        enh_en = 1; nine_bit = 1; ramp(0, 120, 20); ramp(120, 0, -20);
        nine_bit = 0;
        // replacement: stop pending then release
        auto_ack = 0; n_stop = 0; n_go = 0;
        @(negedge clk); rx_level = 100;
        @(negedge clk); rx_level = 5;
        repeat (3) @(negedge clk);
        chk(ins_req == 1 && ins_char == xon1, "R7 replaced by resume", ins_char, xon1);
        auto_ack = 1; repeat (8) @(negedge clk);
        chk(n_stop == 0 && n_go == 1, "R7 single accept", n_stop * 16 + n_go, 1);
        // inverted thresholds
        thr_hi = 50; thr_lo = 100;
        ramp(40, 60, 5); ramp(55, 51, -1);
        chk(rts_n == 1, "R10 still throttled above hi", rts_n, 1);
        @(negedge clk); rx_level = 49; repeat (6) @(negedge clk);
        chk(rts_n == 0, "R10 released below hi", rts_n, 0);
        // drop pending when enhanced goes away
        auto_ack = 0; thr_hi = 96; thr_lo = 32;
        @(negedge clk); rx_level = 100; repeat (3) @(negedge clk);
        chk(ins_req == 1, "R5 pending before drop", ins_req, 1);
        enh_en = 0; repeat (2) @(negedge clk);
        chk(ins_req == 0, "R5 dropped", ins_req, 0);
        enh_en = 1; repeat (4) @(negedge clk);
        chk(ins_req == 0, "R5 not revived", ins_req, 0);
        rx_level = 0; auto_ack = 1; repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule